// File: doc/BRIEF.md
# Cartridge Coprocessor Address Decoder

This block sits on the host CPU's 24-bit address bus inside a cartridge that carries a coprocessor. For every access it picks one of five outcomes: the coprocessor register file, a 2 KB internal RAM, work RAM through an 8 KB banked window, work RAM through a direct linear region, or ROM. Any other address is reported as unmapped. The block passes a translated local address to the selected target and produces a write strobe that only fires when the write is allowed.

The block itself holds the host-side configuration that decoding and protection depend on. This is a 5-bit bank number for the work RAM window, a work RAM write-enable flag, a protected-area size at the bottom of work RAM, and one write-enable bit for each 256-byte chunk of internal RAM. The host writes these through the register file region, using a single-cycle write. All decode outputs are combinational in the current address. A configuration write takes effect from the next clock cycle. ROM bank translation and the coprocessor core belong to other blocks. The read data that the host sees comes from the selected target, and an unmapped read gives 0xFF.

Top module: `cart_addr_decoder`

## Requirements
- R1: In banks 0x00–0x3F and their mirror 0x80–0xBF, offsets 0x2200–0x23FF select the register file (target code 1). The local address is the low 9 bits of the offset.
- R2: In the same banks, offsets 0x3000–0x37FF select internal RAM (target code 2). The local address is the low 11 bits.
- R3: In the same banks, offsets 0x6000–0x7FFF select work RAM (target code 3). The local address is the bank register times 0x2000 plus the low 13 bits, masked to the work RAM size (default 128 KB, 17 bits).
- R4: The window bank register is register index 0x024 and takes data bits 4:0. It resets to 0.
- R5: Banks 0x40–0x4F select work RAM (target code 3) linearly. The local address is the low 20 address bits, masked to the work RAM size. Banks 0xC0–0xCF give ROM, not this region.
- R6: ROM (target code 4) is selected by offsets 0x8000–0xFFFF in banks 0x00–0x3F and 0x80–0xBF, and by all of banks 0xC0–0xFF. The local address is the full 24-bit address. ROM writes never strobe.
- R7: Every other address is unmapped (target code 0). For it the local address is 0, no write strobe fires, and the read data is 0xFF. For a mapped target the read data is the target's data.
- R8: The internal RAM write-enable register is index 0x029. Bit n allows writes to the 256-byte chunk n (local address bits 10:8). It resets to 0, which blocks every internal RAM write.
- R9: The protected-area register is index 0x028. Its data bits 3:0 times 0x100 give the size of a protected area at the bottom of work RAM. While the work RAM write enable (index 0x026, data bit 7) is clear, a work RAM write whose local address falls below that size gives no strobe. Writes above it, and all reads, are unaffected.
- R10: With the work RAM write enable set, writes into the protected area strobe.
- R11: A register file write always strobes. A configuration register is loaded at the clock edge of the cycle in which it is written, and decoding uses it from the next cycle on. Index decoding also works through the 0x80–0xBF mirror.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 24 | Host address |
| bus_wr | input | 1 | The current access is a write |
| bus_wdata | input | 8 | Host write data |
| tgt_rdata | input | 8 | Read data from the selected target |
| tgt_sel | output | 3 | Target code: 0 none, 1 registers, 2 internal RAM, 3 work RAM, 4 ROM |
| loc_addr | output | 24 | Translated local address |
| wr_stb | output | 1 | Write strobe, gated by protection |
| bus_rdata | output | 8 | Read data returned to the host |

## Verification
The target code, local address, strobe and read data are combinational. The bench therefore drives each address on a falling edge and samples one time unit later, in the same cycle. A configuration write is driven in one cycle, is loaded at the next rising edge, and is only checked through the decode of the access that follows. This keeps every check one cycle behind the write that it depends on. The reset check repeats this after a mid-run reset and confirms that the bank and the enables have returned to zero, using only the port behaviour.

// File: rtl/cart_dec_pkg.sv
// Shared types for the cartridge address decoder.
// Assumes a 24-bit host bus and the five target classes below.
package cart_dec_pkg;

    localparam int ADDR_W    = 24;
    localparam int BANK_W    = 5;
    localparam int PROT_W    = 4;
    localparam int CHUNKS    = 8;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_REGS = 3'd1,
        TGT_IRAM = 3'd2,
        TGT_WRAM = 3'd3,
        TGT_ROM  = 3'd4
    } cart_tgt_e;

    typedef struct packed {
        logic [BANK_W-1:0] wram_bank;
        logic              wram_we;
        logic [PROT_W-1:0] prot_size;
        logic [CHUNKS-1:0] iram_we;
    } cart_cfg_t;

endpackage

// File: rtl/cart_region_dec.sv
// Region decoder: maps a host address to a target and a local address.
// Assumes WRAM_AW <= 20. Purely combinational.
module cart_region_dec
    import cart_dec_pkg::*;
#(
    parameter int WRAM_AW = 17,
    parameter int REG_AW  = 9,
    parameter int IRAM_AW = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] wram_bank,
    output cart_tgt_e         tgt,
    output logic [ADDR_W-1:0] loc
);

    localparam int WIN_AW = 13;
    localparam logic [ADDR_W-1:0] WRAM_MASK = ADDR_W'((64'd1 << WRAM_AW) - 64'd1);
    localparam logic [ADDR_W-1:0] REG_MASK  = ADDR_W'((64'd1 << REG_AW) - 64'd1);
    localparam logic [ADDR_W-1:0] IRAM_MASK = ADDR_W'((64'd1 << IRAM_AW) - 64'd1);

    logic [7:0]        bank;
    logic [15:0]       off;
    logic [ADDR_W-1:0] win_addr;

    assign bank = addr[23:16];
    assign off  = addr[15:0];

    // Window address: selected bank followed by the 13-bit offset.
    always_comb begin
        win_addr = {{(ADDR_W-BANK_W-WIN_AW){1'b0}}, wram_bank, off[WIN_AW-1:0]} & WRAM_MASK;
    end

    // Target selection and address translation.
    always_comb begin
        tgt = TGT_NONE;
        loc = '0;
        if (!bank[6]) begin
            if (off[15]) begin
                tgt = TGT_ROM;
                loc = addr;
            end else if (off >= 16'h2200 && off <= 16'h23FF) begin
                tgt = TGT_REGS;
                loc = addr & REG_MASK;
            end else if (off >= 16'h3000 && off <= 16'h37FF) begin
                tgt = TGT_IRAM;
                loc = addr & IRAM_MASK;
            end else if (off >= 16'h6000) begin
                tgt = TGT_WRAM;
                loc = win_addr;
            end
        end else if (bank[7]) begin
            tgt = TGT_ROM;
            loc = addr;
        end else if (bank[7:4] == 4'h4) begin
            tgt = TGT_WRAM;
            loc = {4'h0, addr[19:0]} & WRAM_MASK;
        end
    end

endmodule

// File: rtl/cart_cfg_regs.sv
// Host-side configuration registers written through the register file region.
// Assumes a write is a single-cycle strobe. The index values are fixed by the register map.
module cart_cfg_regs
    import cart_dec_pkg::*;
#(
    parameter logic [8:0] IDX_BANK    = 9'h024,
    parameter logic [8:0] IDX_WRAM_WE = 9'h026,
    parameter logic [8:0] IDX_PROT    = 9'h028,
    parameter logic [8:0] IDX_IRAM_WE = 9'h029
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [8:0] reg_idx,
    input  logic [7:0] wdata,
    output cart_cfg_t  cfg
);

    // Load the addressed field on a register write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (reg_wr) begin
            case (reg_idx)
                IDX_BANK:    cfg.wram_bank <= wdata[BANK_W-1:0];
                IDX_WRAM_WE: cfg.wram_we   <= wdata[7];
                IDX_PROT:    cfg.prot_size <= wdata[PROT_W-1:0];
                IDX_IRAM_WE: cfg.iram_we   <= wdata;
                default:     cfg           <= cfg;
            endcase
        end
    end

endmodule

// File: rtl/cart_wr_guard.sv
// Write guard: turns a write request into a strobe according to target and protection.
// Assumes 256-byte protection granules for both RAMs. Combinational.
module cart_wr_guard
    import cart_dec_pkg::*;
#(
    parameter int CHUNK_AW = 8
) (
    input  cart_tgt_e         tgt,
    input  logic [ADDR_W-1:0] loc,
    input  logic              wr,
    input  cart_cfg_t         cfg,
    output logic              stb
);

    localparam int LIM_W = PROT_W + CHUNK_AW;

    logic [LIM_W-1:0] prot_limit;
    logic             in_prot;
    logic             chunk_ok;

    // Protected area size and membership of the current address.
    always_comb begin
        prot_limit = {cfg.prot_size, {CHUNK_AW{1'b0}}};
        in_prot    = (loc < ADDR_W'(prot_limit));
        chunk_ok   = cfg.iram_we[loc[CHUNK_AW +: $clog2(CHUNKS)]];
    end

    // Per-target write permission.
    always_comb begin
        case (tgt)
            TGT_REGS: stb = wr;
            TGT_IRAM: stb = wr && chunk_ok;
            TGT_WRAM: stb = wr && (cfg.wram_we || !in_prot);
            default:  stb = 1'b0;
        endcase
    end

endmodule

// File: rtl/cart_addr_decoder.sv
// Top: cartridge coprocessor address decoder.
// Decodes host addresses and gates writes. Configuration is loaded on the next edge.
module cart_addr_decoder
    import cart_dec_pkg::*;
#(
    parameter int WRAM_AW = 17
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [23:0] bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    input  logic [7:0]  tgt_rdata,
    output logic [2:0]  tgt_sel,
    output logic [23:0] loc_addr,
    output logic        wr_stb,
    output logic [7:0]  bus_rdata
);

    cart_tgt_e tgt;
    cart_cfg_t cfg;
    logic      reg_wr;

    cart_region_dec #(.WRAM_AW(WRAM_AW)) u_region (
        .addr      (bus_addr),
        .wram_bank (cfg.wram_bank),
        .tgt       (tgt),
        .loc       (loc_addr)
    );

    // Register file writes feed the configuration block.
    assign reg_wr = bus_wr && (tgt == TGT_REGS);

    cart_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_wr  (reg_wr),
        .reg_idx (loc_addr[8:0]),
        .wdata   (bus_wdata),
        .cfg     (cfg)
    );

    cart_wr_guard u_guard (
        .tgt (tgt),
        .loc (loc_addr),
        .wr  (bus_wr),
        .cfg (cfg),
        .stb (wr_stb)
    );

    // Unmapped reads return the open-bus value.
    always_comb begin
        tgt_sel   = tgt;
        bus_rdata = (tgt == TGT_NONE) ? 8'hFF : tgt_rdata;
    end

endmodule

// File: rtl/cart_addr_decoder_chk.sv
// Checker for the decoder's port behaviour. It is bound to the top module.
module cart_addr_decoder_chk #(
    parameter int WRAM_AW = 17
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [2:0]  tgt_sel,
    input logic [23:0] loc_addr,
    input logic        wr_stb,
    input logic [7:0]  bus_rdata
);

    assert_unmapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel == 3'd0) |-> (bus_rdata == 8'hFF && !wr_stb && loc_addr == 24'd0));

    assert_rom_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel == 3'd4) |-> !wr_stb);

    assert_reg_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel == 3'd1 && bus_wr) |-> wr_stb);

    assert_reg_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel == 3'd1) |-> (loc_addr < 24'h200));

    assert_iram_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel == 3'd2) |-> (loc_addr < 24'h800));

    assert_wram_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel == 3'd3) |-> (loc_addr < 24'(64'd1 << WRAM_AW)));

    assert_strobe_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> bus_wr);

    assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel <= 3'd4);

endmodule

bind cart_addr_decoder cart_addr_decoder_chk #(.WRAM_AW(WRAM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .tgt_sel   (tgt_sel),
    .loc_addr  (loc_addr),
    .wr_stb    (wr_stb),
    .bus_rdata (bus_rdata)
);

// File: tb/test_cart_addr_decoder.sv
module test_cart_addr_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    // {addr, wr, tgt, loc, stb}
    localparam logic [52:0] VEC [NVEC] = '{
        {24'h002200, 1'b0, 3'd1, 24'h000000, 1'b0},
        {24'h3F23FF, 1'b1, 3'd1, 24'h0001FF, 1'b1},
        {24'h802300, 1'b0, 3'd1, 24'h000100, 1'b0},
        {24'h003000, 1'b1, 3'd2, 24'h000000, 1'b0},
        {24'h1237FF, 1'b0, 3'd2, 24'h0007FF, 1'b0},
        {24'h006000, 1'b1, 3'd3, 24'h000000, 1'b1},
        {24'h007FFF, 1'b0, 3'd3, 24'h001FFF, 1'b0},
        {24'h400000, 1'b0, 3'd3, 24'h000000, 1'b0},
        {24'h4FFFFF, 1'b0, 3'd3, 24'h01FFFF, 1'b0},
        {24'h431234, 1'b1, 3'd3, 24'h011234, 1'b1},
        {24'hC00000, 1'b0, 3'd4, 24'hC00000, 1'b0},
        {24'hC51234, 1'b1, 3'd4, 24'hC51234, 1'b0},
        {24'h008000, 1'b0, 3'd4, 24'h008000, 1'b0},
        {24'hBFFFFF, 1'b0, 3'd4, 24'hBFFFFF, 1'b0},
        {24'h500000, 1'b1, 3'd0, 24'h000000, 1'b0},
        {24'h001000, 1'b0, 3'd0, 24'h000000, 1'b0},
        {24'h0021FF, 1'b0, 3'd0, 24'h000000, 1'b0},
        {24'h7F0000, 1'b0, 3'd0, 24'h000000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  tgt_rdata = 8'h5A;
    logic [2:0]  tgt_sel;
    logic [23:0] loc_addr;
    logic        wr_stb;
    logic [7:0]  bus_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    cart_addr_decoder i_cart_addr_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .tgt_rdata (tgt_rdata),
        .tgt_sel   (tgt_sel),
        .loc_addr  (loc_addr),
        .wr_stb    (wr_stb),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic drive(input logic [23:0] a, input logic w, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wr    = w;
        bus_wdata = d;
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, bus_addr, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: bank 0, internal RAM writes blocked (R4, R8)
        drive(24'h006005, 1'b1, 8'h00);
        chk("R4", {8'h0, loc_addr}, 32'h5);
        drive(24'h003000, 1'b1, 8'h00);
        chk("R8", {31'h0, wr_stb}, 32'h0);

        // Vector table (R1 R2 R3 R5 R6 R7 R11)
        for (int i = 0; i < NVEC; i++) begin
            logic [52:0] v;
            v = VEC[i];
            drive(v[52:29], v[28], 8'h00);
            chk("R1/R2/R3/R5/R6 tgt", {29'h0, tgt_sel}, {29'h0, v[27:25]});
            chk("R1/R2/R3/R5/R6 loc", {8'h0, loc_addr}, {8'h0, v[24:1]});
            chk("R6/R11 stb", {31'h0, wr_stb}, {31'h0, v[0]});
            chk("R7 rdata", {24'h0, bus_rdata}, (v[27:25] == 3'd0) ? 32'hFF : 32'h5A);
        end

        // Window bank register (R4, R3, R11)
        drive(24'h002224, 1'b1, 8'hFF);
        chk("R11", {31'h0, wr_stb}, 32'h1);
        drive(24'h006005, 1'b0, 8'h00);
        chk("R3", {8'h0, loc_addr}, 32'h1E005);
        drive(24'h802224, 1'b1, 8'hE3);
        drive(24'h807FFF, 1'b0, 8'h00);
        chk("R4", {8'h0, loc_addr}, 32'h7FFF);
        drive(24'h4F0010, 1'b0, 8'h00);
        chk("R5", {8'h0, loc_addr}, 32'h10010);

        // Protected area (R9, R10)
        drive(24'h002228, 1'b1, 8'hF2);
        drive(24'h4001FF, 1'b1, 8'h00);
        chk("R9", {31'h0, wr_stb}, 32'h0);
        drive(24'h400200, 1'b1, 8'h00);
        chk("R9", {31'h0, wr_stb}, 32'h1);
        drive(24'h002224, 1'b1, 8'h00);
        drive(24'h006100, 1'b1, 8'h00);
        chk("R9", {31'h0, wr_stb}, 32'h0);
        drive(24'h400100, 1'b0, 8'h00);
        chk("R9", {29'h0, tgt_sel}, 32'h3);
        drive(24'h002226, 1'b1, 8'h80);
        drive(24'h4001FF, 1'b1, 8'h00);
        chk("R10", {31'h0, wr_stb}, 32'h1);
        drive(24'h002226, 1'b1, 8'h7F);
        drive(24'h400000, 1'b1, 8'h00);
        chk("R10", {31'h0, wr_stb}, 32'h0);

        // Internal RAM chunk enables (R8)
        drive(24'h002229, 1'b1, 8'h05);
        drive(24'h003000, 1'b1, 8'h00);
        chk("R8", {31'h0, wr_stb}, 32'h1);
        drive(24'h003100, 1'b1, 8'h00);
        chk("R8", {31'h0, wr_stb}, 32'h0);
        drive(24'h8032FF, 1'b1, 8'h00);
        chk("R8", {31'h0, wr_stb}, 32'h1);
        drive(24'h0037FF, 1'b1, 8'h00);
        chk("R8", {31'h0, wr_stb}, 32'h0);

        // Mid-run reset clears bank and enables (R4, R8)
        drive(24'h002224, 1'b1, 8'h07);
        rst_n = 1'b0;
        drive(24'h000000, 1'b0, 8'h00);
        rst_n = 1'b1;
        drive(24'h006005, 1'b0, 8'h00);
        chk("R4", {8'h0, loc_addr}, 32'h5);
        drive(24'h003000, 1'b1, 8'h00);
        chk("R8", {31'h0, wr_stb}, 32'h0);

        summary();
    end

endmodule